// File: doc/BRIEF.md
# Pin Edge and Level Interrupt Detector

This block watches a group of asynchronous input pins. For each pin it raises an interrupt request when that pin shows the condition selected for its channel. The condition can be a rising edge, a falling edge, either edge, a low level or a high level. Every pin is first brought into the clock domain through a synchronizer chain. Edges are found by comparing the newest synchronized sample with the one from the cycle before.

Each channel holds three result bits:
- a request status bit that also drives the channel's interrupt line;
- a sticky rising-edge flag;
- a sticky falling-edge flag.

The flags are kept apart from the status, so software can clear the request and still see which edge caused it, or clear the reverse way round. All three groups are cleared by write-one-to-clear masks, one bit per channel. A channel's mode is loaded through a small write port that takes a channel index and a five-bit mode value.

Top module: `pintdet_top`

## Requirements
- R1: After reset every status bit, rising flag, falling flag and interrupt line is 0, and every channel is disabled (mode 0x00).
- R2: A pin change passes through two synchronizer stages and one history register. With the pin changed between clock edges, its effect on status or flags appears after the third following rising clock edge, and not after the second.
- R3: Mode value 0x01 (bit 0 = rising enable, bit 4 = 0 meaning edge sensing) sets status and the rising flag on a 0-to-1 pin transition only.
- R4: Mode value 0x02 (bit 1 = falling enable in edge sensing) sets status and the falling flag on a 1-to-0 pin transition only.
- R5: Mode value 0x03 sets status on both transitions, with the rising flag set on a rising transition and the falling flag set on a falling one.
- R6: Mode 0x00 disables the channel, and so does any value other than 0x01, 0x02, 0x03, 0x10 and 0x12 (for example 0x11). A disabled channel never sets its status or flags.
- R7: In edge sensing the status bit stays 1 until a 1 is written to that channel's bit of the status clear mask.
- R8: Mode value 0x10 (bit 4 = 1 level sensing, bit 1 = 0 active low) makes the status show the synchronized pin being low. A clear write has no effect while the pin stays low, and the status drops by itself once the pin goes high.
- R9: Mode value 0x12 (bit 1 = 1 active high in level sensing) makes the status show the synchronized pin being high.
- R10: The rising and falling flags are set only by enabled edges in edge sensing, never in level sensing. Clearing the status leaves the flags alone, and clearing one group of flags leaves the other group and the status alone.
- R11: The rising and falling flags are write-one-to-clear per bit, and an all-ones mask clears that group on every channel in one cycle.
- R12: When a set event and a clear of the same bit fall in the same cycle, the bit ends at 1.
- R13: Each interrupt line equals its channel's status bit.
- R14: A mode write changes only the channel named by the index, so channels behave independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | CHANNELS | Asynchronous pins to watch, one per channel |
| cfg_we | input | 1 | Mode write strobe |
| cfg_idx | input | IDX_W | Channel index for the mode write |
| cfg_mode | input | 5 | Mode value to load |
| clr_status | input | CHANNELS | Write-one-to-clear mask for the status bits |
| clr_rise | input | CHANNELS | Write-one-to-clear mask for the rising flags |
| clr_fall | input | CHANNELS | Write-one-to-clear mask for the falling flags |
| status | output | CHANNELS | Request status per channel |
| rise_flag | output | CHANNELS | Sticky rising-edge flags |
| fall_flag | output | CHANNELS | Sticky falling-edge flags |
| irq | output | CHANNELS | Interrupt request line per channel |

## Verification
Four properties are checked on every cycle:
- a level-sensing status equals the pin condition of the previous cycle;
- an edge-sensing status that is not cleared stays set;
- an edge event always lands in its flag, even against a clear;
- a clear with no competing event empties the flag.

Some behaviour only the bench scenarios can show:
- the exact three-edge latency through the synchronizer;
- the decode of every legal mode, and the disabling of illegal ones;
- all-ones mask clears;
- that a mode write reaches only the indexed channel.

// File: rtl/pintdet_pkg.sv
package pintdet_pkg;

   localparam int MODE_W = 5;

   // mode values; bit 4 selects level sensing, bit 1 is falling/high, bit 0 rising
   localparam logic [MODE_W-1:0] MODE_OFF  = 5'h00;
   localparam logic [MODE_W-1:0] MODE_RISE = 5'h01;
   localparam logic [MODE_W-1:0] MODE_FALL = 5'h02;
   localparam logic [MODE_W-1:0] MODE_BOTH = 5'h03;
   localparam logic [MODE_W-1:0] MODE_LOW  = 5'h10;
   localparam logic [MODE_W-1:0] MODE_HIGH = 5'h12;

   typedef struct packed {
      logic level_sense;
      logic level_high;
      logic edge_rise;
      logic edge_fall;
   } chan_cfg_t;

   function automatic chan_cfg_t decode_mode(input logic [MODE_W-1:0] m);
      chan_cfg_t c;
      c = '0;
      case (m)
         MODE_RISE: c.edge_rise = 1'b1;
         MODE_FALL: c.edge_fall = 1'b1;
         MODE_BOTH: begin
            c.edge_rise = 1'b1;
            c.edge_fall = 1'b1;
         end
         MODE_LOW:  c.level_sense = 1'b1;
         MODE_HIGH: begin
            c.level_sense = 1'b1;
            c.level_high  = 1'b1;
         end
         default:   c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pintdet_sync.sv
module pintdet_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("pintdet_sync: WIDTH must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("pintdet_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pintdet_edge.sv
module pintdet_edge #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise_evt,
   output logic [WIDTH-1:0] fall_evt
);

   logic [WIDTH-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else begin
         hist_q <= lvl;
      end
   end

   assign rise_evt = lvl & ~hist_q;
   assign fall_evt = ~lvl & hist_q;

endmodule

// File: rtl/pintdet_chan.sv
module pintdet_chan
   import pintdet_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [MODE_W-1:0] cfg_mode,
   input  logic              lvl,
   input  logic              rise_evt,
   input  logic              fall_evt,
   input  logic              clr_status,
   input  logic              clr_rise,
   input  logic              clr_fall,
   output logic              status,
   output logic              rise_flag,
   output logic              fall_flag
);

   chan_cfg_t cfg_q;
   logic      status_q;
   logic      rise_q;
   logic      fall_q;
   logic      cond;
   logic      rise_set;
   logic      fall_set;
   logic      status_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_we) begin
         cfg_q <= decode_mode(cfg_mode);
      end
   end

   assign cond     = cfg_q.level_high ? lvl : ~lvl;
   assign rise_set = rise_evt & cfg_q.edge_rise;
   assign fall_set = fall_evt & cfg_q.edge_fall;

   always_comb begin
      if (cfg_q.level_sense) begin
         status_d = cond;
      end else begin
         status_d = (status_q & ~clr_status) | rise_set | fall_set;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
         rise_q   <= 1'b0;
         fall_q   <= 1'b0;
      end else begin
         status_q <= status_d;
         rise_q   <= (rise_q & ~clr_rise) | rise_set;
         fall_q   <= (fall_q & ~clr_fall) | fall_set;
      end
   end

   assign status    = status_q;
   assign rise_flag = rise_q;
   assign fall_flag = fall_q;

   // level sensing tracks the pin condition of the previous cycle
   assert_level_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_q.level_sense) |-> (status_q == $past(cond)));

   // edge sensing status holds until cleared
   assert_edge_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cfg_q.level_sense && status_q && !clr_status) |-> status_q);

   // an event beats a simultaneous clear
   assert_rise_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rise_set) |-> rise_q);

   assert_fall_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fall_set) |-> fall_q);

   // a clear with no competing event empties the flag
   assert_rise_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_rise && !rise_set) |-> !rise_q);

endmodule

// File: rtl/pintdet_top.sv
module pintdet_top #(
   parameter int  CHANNELS    = 8,
   parameter int  SYNC_STAGES = 2,
   localparam int IDX_W       = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CHANNELS-1:0] pin_in,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_idx,
   input  logic [4:0]          cfg_mode,
   input  logic [CHANNELS-1:0] clr_status,
   input  logic [CHANNELS-1:0] clr_rise,
   input  logic [CHANNELS-1:0] clr_fall,
   output logic [CHANNELS-1:0] status,
   output logic [CHANNELS-1:0] rise_flag,
   output logic [CHANNELS-1:0] fall_flag,
   output logic [CHANNELS-1:0] irq
);

   if (CHANNELS < 1) begin : g_bad_channels
      $error("pintdet_top: CHANNELS must be at least 1");
   end

   logic [CHANNELS-1:0] pin_sync;
   logic [CHANNELS-1:0] rise_evt;
   logic [CHANNELS-1:0] fall_evt;

   pintdet_sync #(
      .WIDTH  (CHANNELS),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   pintdet_edge #(
      .WIDTH (CHANNELS)
   ) i_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (pin_sync),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
      logic we_i;
      assign we_i = cfg_we && (cfg_idx == IDX_W'(i));

      pintdet_chan i_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .cfg_we     (we_i),
         .cfg_mode   (cfg_mode),
         .lvl        (pin_sync[i]),
         .rise_evt   (rise_evt[i]),
         .fall_evt   (fall_evt[i]),
         .clr_status (clr_status[i]),
         .clr_rise   (clr_rise[i]),
         .clr_fall   (clr_fall[i]),
         .status     (status[i]),
         .rise_flag  (rise_flag[i]),
         .fall_flag  (fall_flag[i])
      );
   end

   assign irq = status;

endmodule

// File: tb/test_pintdet_top.sv
module test_pintdet_top;

   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin_in = '0;
   logic         cfg_we = 1'b0;
   logic [2:0]   cfg_idx = '0;
   logic [4:0]   cfg_mode = '0;
   logic [N-1:0] clr_status = '0;
   logic [N-1:0] clr_rise = '0;
   logic [N-1:0] clr_fall = '0;
   logic [N-1:0] status, rise_flag, fall_flag, irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   typedef struct {
      int           when;
      logic [N-1:0] st;
      logic [N-1:0] rf;
      logic [N-1:0] ff;
      string        tag;
   } exp_t;

   exp_t sb_q[$];
   logic [N-1:0] exp_st = '0, exp_rf = '0, exp_ff = '0;

   pintdet_top i_pintdet_top (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mode(cfg_mode),
      .clr_status(clr_status), .clr_rise(clr_rise), .clr_fall(clr_fall),
      .status(status), .rise_flag(rise_flag), .fall_flag(fall_flag), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic cmp(input string what, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   // monitor: pops items due in this cycle and compares them
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].when == cyc) begin
         cmp("status", sb_q[0].tag, status, sb_q[0].st);
         cmp("rise_flag", sb_q[0].tag, rise_flag, sb_q[0].rf);
         cmp("fall_flag", sb_q[0].tag, fall_flag, sb_q[0].ff);
         cmp("irq R13", sb_q[0].tag, irq, sb_q[0].st);
         void'(sb_q.pop_front());
      end
   end

   task automatic expect_in(input int d, input string tag);
      exp_t e;
      e.when = cyc + d;
      e.st = exp_st;
      e.rf = exp_rf;
      e.ff = exp_ff;
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      while (sb_q.size() != 0) @(negedge clk);
      tick(1);
   endtask

   task automatic write_mode(input int ch, input logic [4:0] m);
      cfg_we = 1'b1;
      cfg_idx = 3'(ch);
      cfg_mode = m;
      tick(1);
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      expect_in(1, "R1 reset state");
      drain();

      // R3 R5 R6: edge modes, disabled and illegal modes
      write_mode(0, 5'h01);
      write_mode(1, 5'h02);
      write_mode(2, 5'h03);
      write_mode(3, 5'h00);
      write_mode(7, 5'h11);
      pin_in = 8'h8F;
      expect_in(2, "R2 not yet visible");
      exp_st = 8'h05; exp_rf = 8'h05;
      expect_in(3, "R2 R3 R5 R6 rising");
      drain();

      pin_in = 8'h00;
      exp_st = 8'h07; exp_ff = 8'h06;
      expect_in(3, "R4 R5 R7 falling");
      drain();

      // R7 R10: status clear leaves flags
      clr_status = 8'h01;
      exp_st = 8'h06;
      expect_in(1, "R7 R10 status clear");
      tick(1);
      clr_status = '0;
      drain();

      // R11 R10: all-ones flag clears
      clr_rise = 8'hFF;
      exp_rf = 8'h00;
      expect_in(1, "R11 R10 rise clear all");
      tick(1);
      clr_rise = '0;
      clr_fall = 8'hFF;
      exp_ff = 8'h00;
      expect_in(1, "R11 fall clear all");
      tick(1);
      clr_fall = '0;
      clr_status = 8'hFF;
      exp_st = 8'h00;
      expect_in(1, "R7 status clear all");
      tick(1);
      clr_status = '0;
      drain();

      // R8 R9 R10: level modes
      write_mode(4, 5'h10);
      write_mode(5, 5'h12);
      exp_st = 8'h10;
      expect_in(2, "R8 low level active");
      drain();
      clr_status = 8'h10;
      expect_in(1, "R8 clear ignored while low");
      tick(1);
      clr_status = '0;
      drain();
      pin_in = 8'h30;
      exp_st = 8'h20;
      expect_in(3, "R8 R9 R10 level swap");
      drain();
      pin_in = 8'h00;
      exp_st = 8'h10;
      expect_in(3, "R8 R9 level back");
      drain();

      // R12: event and clear in the same cycle
      pin_in = 8'h01;
      exp_st = 8'h11; exp_rf = 8'h01;
      tick(2);
      clr_status = 8'h01;
      clr_rise = 8'h01;
      expect_in(1, "R12 set wins");
      tick(1);
      clr_status = '0;
      clr_rise = '0;
      expect_in(2, "R12 still set");
      drain();

      // R14 R6: write reaches only the indexed channel
      write_mode(6, 5'h03);
      pin_in = 8'hC1;
      exp_st = 8'h51; exp_rf = 8'h41;
      expect_in(3, "R14 R6 independent channels");
      drain();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule